// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor port and a main-memory port and keeps a copy of recently read memory blocks. The byte address is 24 bits wide and a block is one 32-bit word of four bytes. Every block has exactly one line it may occupy. That line is the block number modulo the line count, so no replacement choice is ever made. A read that finds its block resident is answered from the line without any memory traffic. A read that misses first fetches the whole block into its line and then answers from the line. Every write goes to memory at once. If the written block is resident, its line is patched in the same step, so lines are never dirty.

The processor raises `cpu_req` with a command and holds the command steady until `cpu_ready` pulses for one cycle. The memory side uses the same hold-until-acknowledge discipline with `mem_req` and `mem_ack`. The line count is set by the `INDEX_W` parameter. A value of 14 gives the full 16K-line layout with an 8-bit tag.

The controller has four states. `ST_IDLE` waits for a request. From `ST_IDLE` the path `idle_to_resp` is taken on a read hit, `idle_to_fill` on a read miss and `idle_to_write` on any write. `ST_FILL` holds a memory read and takes `fill_to_resp` on acknowledge, loading the line. `ST_WRITE` holds a memory write and takes `write_to_resp` on acknowledge, patching the line on a hit. `ST_RESP` raises `cpu_ready` for one cycle and always takes `resp_to_idle`.

Top module: `dmc_cache`

## Requirements
- R1: The address splits, from most to least significant, into a tag of 24-INDEX_W-2 bits, an INDEX_W-bit line index (bits INDEX_W+1..2) and a 2-bit byte offset (bits 1..0). A block is only ever held in the line its index selects.
- R2: After reset every line is invalid, so the first read of any address is a miss.
- R3: A read whose line is valid and whose stored tag equals the address tag is a hit. `cpu_ready` rises in the cycle after the request is sampled, and no memory request is issued.
- R4: A read miss issues exactly one memory read with `mem_we`=0 and a block-aligned `mem_addr` (bits 1..0 zero). It writes the returned word, the tag and the valid bit into the line, then returns data taken from the line.
- R5: A block that maps to an occupied line overwrites it, so the previous block misses on its next read.
- R6: Every write issues exactly one memory write with `mem_we`=1 and a block-aligned `mem_addr`, and `cpu_ready` stays low until `mem_ack`.
- R7: A write hit merges the written bytes into the line, and a following read of that block hits and returns the new value.
- R8: A write miss leaves the cache unchanged, so a following read of that block misses and fetches the value the write put in memory.
- R9: With `cpu_byte`=1, the lane is addr[1:0], and lane k is data bits 8k+7..8k. A byte read returns the lane zero-extended. A byte write drives strobe 1<<k and carries the byte in that lane. With `cpu_byte`=0, addr[1:0] is ignored, the full word is read and the write strobe is 4'hF.
- R10: `cpu_ready` is a single-cycle pulse, and `mem_req` with its command stays high until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 32 | Write data (byte in bits 7..0 for byte writes) |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write command |
| mem_addr | output | 24 | Block-aligned memory address |
| mem_wdata | output | 32 | Memory write data, lane placed |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle |

## Verification
Two functions can fall on the same clock edge. On a write hit, the acknowledge that completes the write-through also patches the resident line. The bench provokes this by writing words and single bytes to lines it has just filled, with memory latency rotating from zero to three cycles. It then judges the result two ways: a read-back must hit in one cycle with no memory read and return the merged value, and the memory model must hold the same bytes. A long mixed sweep over a few conflicting tags repeats this against a bench-side model of residency and memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_RESP
    } dmc_state_t;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int INDEX_W = 6,
    parameter int TAG_W   = 16,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [INDEX_W-1:0]   idx,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 fill_en,
    input  logic                 upd_en,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [DATA_W/8-1:0]  wr_strb
);
    localparam int LINES = 1 << INDEX_W;
    localparam int LANES = DATA_W / 8;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic             wr_any;

    assign wr_any = fill_en | upd_en;

    // Valid bits: cleared by reset, set only by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_tag   = tag_q[idx];

    // One byte-wide array per lane, so that partial updates stay separate.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_mem [LINES];
        always_ff @(posedge clk) begin
            if (wr_any && (fill_en || wr_strb[l])) begin
                lane_mem[idx] <= wr_data[l*8 +: 8];
            end
        end
        assign rd_data[l*8 +: 8] = lane_mem[idx];
    end

    // R2: a reset cycle leaves every line invalid
    p_lines_invalid_after_reset_r2: assert property (
        @(posedge clk) !rst_n |=> (valid_q == '0));
endmodule

// File: rtl/dmc_lane_unit.sv
module dmc_lane_unit #(
    parameter int DATA_W = 32
) (
    input  logic                        is_byte,
    input  logic [$clog2(DATA_W/8)-1:0] offs,
    input  logic [DATA_W-1:0]           cpu_wdata,
    input  logic [DATA_W-1:0]           line_word,
    output logic [DATA_W/8-1:0]         strb,
    output logic [DATA_W-1:0]           lane_wdata,
    output logic [DATA_W-1:0]           rd_out
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] sel_byte;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign strb[l] = is_byte ? (offs == l[$clog2(DATA_W/8)-1:0]) : 1'b1;
        assign lane_wdata[l*8 +: 8] = is_byte ? cpu_wdata[7:0] : cpu_wdata[l*8 +: 8];
    end

    assign sel_byte = line_word[offs*8 +: 8];
    assign rd_out   = is_byte ? {{(DATA_W-8){1'b0}}, sel_byte} : line_word;
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic hit,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic mem_req,
    output logic mem_we,
    output logic fill_en,
    output logic upd_en
);
    dmc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we)   state_d = ST_WRITE;  // idle_to_write
                    else if (hit) state_d = ST_RESP;   // idle_to_resp
                    else          state_d = ST_FILL;   // idle_to_fill
                end
            end
            ST_FILL:  if (mem_ack) state_d = ST_RESP;  // fill_to_resp
            ST_WRITE: if (mem_ack) state_d = ST_RESP;  // write_to_resp
            ST_RESP:  state_d = ST_IDLE;               // resp_to_idle
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_en   = 1'b0;
        upd_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FILL: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                upd_en  = mem_ack && hit;
            end
            ST_RESP: cpu_ready = 1'b1;
            default: ;
        endcase
    end

    // R3: a read hit answers next cycle without memory traffic
    p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !cpu_we && hit) |=> (cpu_ready && !mem_req));
    // R4: a read miss starts a memory read
    p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !cpu_we && !hit) |=> (mem_req && !mem_we));
    // R6: every write is forwarded to memory
    p_write_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && cpu_we) |=> (mem_req && mem_we && !cpu_ready));
    // R10: ready is a single pulse
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R10: memory request held until acknowledge
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic                 cpu_byte,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 cpu_ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [DATA_W/8-1:0]  mem_wstrb,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ack
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;

    logic [TAG_W-1:0]   a_tag;
    logic [INDEX_W-1:0] a_idx;
    logic [OFF_W-1:0]   a_off;
    logic               line_valid;
    logic [TAG_W-1:0]   line_tag;
    logic [DATA_W-1:0]  line_word;
    logic               hit;
    logic               fill_en, upd_en;
    logic [LANES-1:0]   strb;
    logic [DATA_W-1:0]  lane_wdata;
    logic [DATA_W-1:0]  rd_out;
    logic [DATA_W-1:0]  store_wdata;

    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx = cpu_addr[OFF_W +: INDEX_W];
    assign a_off = cpu_addr[OFF_W-1:0];

    assign hit = line_valid && (line_tag == a_tag);

    dmc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .hit       (hit),
        .mem_ack   (mem_ack),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .fill_en   (fill_en),
        .upd_en    (upd_en)
    );

    dmc_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .is_byte    (cpu_byte),
        .offs       (a_off),
        .cpu_wdata  (cpu_wdata),
        .line_word  (line_word),
        .strb       (strb),
        .lane_wdata (lane_wdata),
        .rd_out     (rd_out)
    );

    assign store_wdata = fill_en ? mem_rdata : lane_wdata;

    dmc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (a_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (line_word),
        .fill_en  (fill_en),
        .upd_en   (upd_en),
        .wr_tag   (a_tag),
        .wr_data  (store_wdata),
        .wr_strb  (strb)
    );

    assign mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wdata = lane_wdata;
    assign mem_wstrb = mem_we ? strb : '0;
    assign cpu_rdata = cpu_ready ? rd_out : '0;

    // R1: memory traffic always uses a block-aligned address
    p_aligned_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));
    // R7: a fill or patch leaves the addressed line hitting in the next cycle
    p_line_hits_after_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en || upd_en) |=> hit);
endmodule

// File: tb/dmc_cache_bench.sv
module dmc_cache_bench;
    localparam int IW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #4 clk = ~clk;

    dmc_cache #(.INDEX_W(IW)) u_dmc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0, lat = 0;
    logic [3:0]  last_strb;
    logic [23:0] last_waddr;
    logic [31:0] last_wdata;
    logic [31:0] ovr [int unsigned];
    logic              rv [1<<IW];
    logic [23-IW-2:0]  rt [1<<IW];

    function automatic logic [31:0] memword(input logic [23:0] a);
        int unsigned k = int'(a[23:2]);
        logic [31:0] base;
        if (ovr.exists(k)) return ovr[k];
        base = {8'h00, a[23:2], 2'b00};
        return base * 32'h9E37_79B1 + 32'h0000_1357;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Memory model: latency rotates 0..3 cycles, one-cycle acknowledge.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                if (mem_we) begin
                    logic [31:0] w;
                    w = memword(mem_addr);
                    for (int l = 0; l < 4; l++)
                        if (mem_wstrb[l]) w[l*8 +: 8] = mem_wdata[l*8 +: 8];
                    ovr[int'(mem_addr[23:2])] = w;
                    wr_cnt++;
                    last_strb  = mem_wstrb;
                    last_waddr = mem_addr;
                    last_wdata = mem_wdata;
                end else begin
                    mem_rdata = memword(mem_addr);
                    rd_cnt++;
                end
                mem_ack = 1'b1;
                wait_cnt = 0;
                lat = (lat + 1) % 4;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic op(input logic we, input logic bsz, input logic [23:0] a,
                      input logic [31:0] wd, input string req);
        logic [IW-1:0] idx = a[IW+1:2];
        logic [23-IW-2:0] tg = a[23:IW+2];
        bit resident = rv[idx] && (rt[idx] == tg);
        int r0 = rd_cnt, w0 = wr_cnt, cyc = 0;
        logic [31:0] got, exp;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_byte = bsz; cpu_addr = a; cpu_wdata = wd;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 60);
        got = cpu_rdata;
        cpu_req = 1'b0;
        chk(cpu_ready === 1'b1, req, "ready seen", {31'b0, cpu_ready}, 32'd1);
        if (!we) begin
            exp = bsz ? ((memword(a) >> (8 * a[1:0])) & 32'hFF) : memword(a);
            chk(got === exp, req, "read data", got, exp);
            chk(rd_cnt - r0 == (resident ? 0 : 1), req, "memory reads",
                rd_cnt - r0, resident ? 0 : 1);
            chk(wr_cnt == w0, req, "no write on read", wr_cnt - w0, 0);
            if (resident) chk(cyc == 1, "R3", "hit latency", cyc, 1);
            rv[idx] = 1'b1;
            rt[idx] = tg;
        end else begin
            chk(wr_cnt - w0 == 1, req, "memory writes", wr_cnt - w0, 1);
            chk(rd_cnt == r0, req, "no read on write", rd_cnt - r0, 0);
            chk(last_waddr == {a[23:2], 2'b00}, "R6", "write address", last_waddr, {a[23:2], 2'b00});
            exp = bsz ? (32'd1 << a[1:0]) : 32'hF;
            chk(last_strb == exp[3:0], "R9", "strobe", last_strb, exp);
            if (bsz) chk(last_wdata[8*a[1:0] +: 8] == wd[7:0], "R9", "lane data",
                         last_wdata[8*a[1:0] +: 8], wd[7:0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg = 32'h1234_5678;
        for (int i = 0; i < (1 << IW); i++) rv[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(cpu_ready === 1'b0, "R2", "ready in reset", {31'b0, cpu_ready}, 0);
        chk(mem_req === 1'b0, "R10", "mem_req in reset", {31'b0, mem_req}, 0);
        rst_n = 1'b1;

        // R2 / R4: every line misses once after reset
        for (int i = 0; i < (1 << IW); i++) op(0, 0, {18'h00123, 4'(i), 2'b00}, 0, "R4");
        // R3 / R1: word reads hit; low offset bits are ignored for words (R9)
        for (int i = 0; i < (1 << IW); i++) op(0, 0, {18'h00123, 4'(i), 2'(i)}, 0, "R3");
        // R9: byte reads on every lane
        for (int k = 0; k < 4; k++) op(0, 1, {18'h00123, 4'd3, 2'(k)}, 0, "R9");
        // R5: conflicting block evicts, neighbour line untouched (R1)
        op(0, 0, {18'h2ABCD, 4'd5, 2'b00}, 0, "R5");
        op(0, 0, {18'h00123, 4'd5, 2'b00}, 0, "R5");
        op(0, 0, {18'h00123, 4'd6, 2'b00}, 0, "R1");
        // R6 / R7: word write hit then read-back hits
        op(1, 0, {18'h00123, 4'd7, 2'b00}, 32'hCAFE_F00D, "R7");
        op(0, 0, {18'h00123, 4'd7, 2'b00}, 0, "R7");
        // R9 / R7: byte writes into each lane, then merged read
        for (int k = 0; k < 4; k++) op(1, 1, {18'h00123, 4'd8, 2'(k)}, 32'h0000_00A0 + k, "R9");
        op(0, 0, {18'h00123, 4'd8, 2'b00}, 0, "R7");
        // R8: write miss does not allocate
        op(1, 0, {18'h3F00F, 4'd9, 2'b00}, 32'h1357_9BDF, "R8");
        op(0, 0, {18'h3F00F, 4'd9, 2'b00}, 0, "R8");
        op(0, 0, {18'h00123, 4'd9, 2'b00}, 0, "R5");

        // Mixed sweep over four conflicting tags
        for (int n = 0; n < 600; n++) begin
            logic [23:0] a;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = {16'h0040, 2'(lcg[9:8]), 4'(lcg[13:10]), 2'(lcg[15:14])};
            op(lcg[20], lcg[21], a, lcg ^ 32'h5A5A_A5A5, lcg[20] ? "R6" : "R4");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule